// File: doc/BRIEF.md
# Branch and Jump Target Unit

This block decides, for one decoded control-transfer instruction, whether the program counter leaves its sequential path and where it goes. It receives the instruction's own address, the two source register values, a 16-bit branch displacement, a 26-bit jump index and a small operation code from the decoder. It returns a taken flag, the destination address, a write enable and value for the return-address register (register 31), and a flag for a misaligned register jump.

Every result is registered, so the outputs describe the operation presented on the previous clock edge. Because the instruction after a branch or jump always executes, all addresses are formed from the delay-slot address (instruction address plus 4), and the return address skips that slot (instruction address plus 8). Conditions are computed directly from the register values, with no stored condition code.

Operation codes (4 bits): 0 none, 1 paged jump, 2 paged jump with link, 3 register jump, 4 register jump with link, 5 branch if equal, 6 branch if not equal, 7 branch if <= 0, 8 branch if > 0, 9 branch if < 0, 10 branch if >= 0, 11 branch if < 0 with link, 12 branch if >= 0 with link, 13 to 15 unused.

Top module: `bju_top`

## Requirements
- R1: While rst_n is low at a clock edge, taken_o, link_we_o and addr_err_o are 0 after that edge.
- R2: Codes 1 and 2 are always taken with target {(pc+4)[31:28], idx_i, 2'b00}.
- R3: Codes 3 and 4 with rs_i[1:0] = 0 are taken with target equal to rs_i.
- R4: Codes 3 and 4 with rs_i[1:0] != 0 give addr_err_o = 1, taken_o = 0 and link_we_o = 0.
- R5: Code 5 is taken when rs_i equals rt_i and code 6 when they differ; the target is pc + 4 + (sign-extended off_i shifted left by 2).
- R6: Codes 7 to 12 compare rs_i as a signed two's-complement value against zero, using the same target rule as R5.
- R7: Codes 2, 4 (when aligned), 11 and 12 assert link_we_o with link_val_o = pc + 8, whether or not the transfer is taken; all other codes leave link_we_o at 0.
- R8: Outputs reflect the inputs sampled at the previous clock edge; with vld_i low, taken_o, link_we_o and addr_err_o are 0.
- R9: Codes 0 and 13 to 15 produce no transfer, no link write and no error.
- R10: A negative displacement moves the target backwards, and all address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vld_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| pc_i | input | 32 | Address of the transfer instruction |
| rs_i | input | 32 | First source register value |
| rt_i | input | 32 | Second source register value |
| off_i | input | 16 | Branch displacement in words |
| idx_i | input | 26 | Jump word index within the page |
| taken_o | output | 1 | Control flow changes |
| target_o | output | 32 | Destination address (meaningful when taken) |
| link_we_o | output | 1 | Write return address to register 31 |
| link_val_o | output | 32 | Return address |
| addr_err_o | output | 1 | Register jump to non-word-aligned address |

## Verification
The hardest cases to reach are the edges of the signed zero compares and the wrap of address sums: a register value of exactly 0, of 0x80000000 and of 0x7FFFFFFF, a jump from the last word of a 256 MB page where pc+4 carries into the page bits, and a backwards displacement from address near zero. The stimulus places these values directly, mixed with a seeded random stream whose register values are biased towards zero and towards equal pairs so that every condition is both taken and not taken. Linking branches are driven with conditions both true and false to show the link write does not depend on the outcome.

// File: rtl/bju_pkg.sv
// Package: shared widths and operation codes for the branch/jump unit.
// Assumes a 32-bit address space with word-aligned instructions.
package bju_pkg;
    localparam int XLEN  = 32;
    localparam int OFFW  = 16;
    localparam int IDXW  = 26;
    localparam int OPW   = 4;

    typedef enum logic [OPW-1:0] {
        OP_NONE  = 4'd0,
        OP_JP    = 4'd1,
        OP_JPL   = 4'd2,
        OP_JR    = 4'd3,
        OP_JRL   = 4'd4,
        OP_BEQ   = 4'd5,
        OP_BNE   = 4'd6,
        OP_BLEZ  = 4'd7,
        OP_BGTZ  = 4'd8,
        OP_BLTZ  = 4'd9,
        OP_BGEZ  = 4'd10,
        OP_BLTZL = 4'd11,
        OP_BGEZL = 4'd12
    } bju_op_e;

    typedef struct packed {
        logic is_jp;
        logic is_jr;
        logic is_br;
        logic is_link;
        logic cond;
    } bju_dec_t;
endpackage

// File: rtl/bju_cond.sv
// Module: decodes the operation code and evaluates the branch condition.
// Assumes register values are two's complement; unknown codes decode to nothing.
module bju_cond
    import bju_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   rs_i,
    input  logic [W-1:0]   rt_i,
    output bju_dec_t       dec_o
);
    logic rs_zero;
    logic rs_neg;

    // Sign and zero flags of the first operand.
    always_comb begin
        rs_zero = (rs_i == '0);
        rs_neg  = rs_i[W-1];
    end

    // Classify the operation and compute whether its condition holds.
    always_comb begin
        dec_o = '0;
        case (op_i)
            OP_JP:    begin dec_o.is_jp = 1'b1; dec_o.cond = 1'b1; end
            OP_JPL:   begin dec_o.is_jp = 1'b1; dec_o.cond = 1'b1; dec_o.is_link = 1'b1; end
            OP_JR:    begin dec_o.is_jr = 1'b1; dec_o.cond = 1'b1; end
            OP_JRL:   begin dec_o.is_jr = 1'b1; dec_o.cond = 1'b1; dec_o.is_link = 1'b1; end
            OP_BEQ:   begin dec_o.is_br = 1'b1; dec_o.cond = (rs_i == rt_i); end
            OP_BNE:   begin dec_o.is_br = 1'b1; dec_o.cond = (rs_i != rt_i); end
            OP_BLEZ:  begin dec_o.is_br = 1'b1; dec_o.cond = rs_neg | rs_zero; end
            OP_BGTZ:  begin dec_o.is_br = 1'b1; dec_o.cond = ~rs_neg & ~rs_zero; end
            OP_BLTZ:  begin dec_o.is_br = 1'b1; dec_o.cond = rs_neg; end
            OP_BGEZ:  begin dec_o.is_br = 1'b1; dec_o.cond = ~rs_neg; end
            OP_BLTZL: begin dec_o.is_br = 1'b1; dec_o.cond = rs_neg; dec_o.is_link = 1'b1; end
            OP_BGEZL: begin dec_o.is_br = 1'b1; dec_o.cond = ~rs_neg; dec_o.is_link = 1'b1; end
            default:  dec_o = '0;
        endcase
    end

    // At most one transfer class is selected for any code.
    always_comb begin
        assert ($onehot0({dec_o.is_jp, dec_o.is_jr, dec_o.is_br}))
            else $error("p_one_class_r9 violated");
    end
endmodule

// File: rtl/bju_addr.sv
// Module: forms the candidate destinations and the return address.
// Assumes instructions are 4 bytes; all sums wrap at the address width.
module bju_addr
    import bju_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int OW = OFFW,
    parameter int IW = IDXW
) (
    input  logic [W-1:0]  pc_i,
    input  logic [OW-1:0] off_i,
    input  logic [IW-1:0] idx_i,
    output logic [W-1:0]  br_tgt_o,
    output logic [W-1:0]  jp_tgt_o,
    output logic [W-1:0]  link_o
);
    localparam int PGW = W - IW - 2;
    localparam int SXW = W - OW - 2;

    logic [W-1:0] slot_pc;
    logic [W-1:0] disp;

    // Delay-slot address and the scaled, sign-extended displacement.
    always_comb begin
        slot_pc = pc_i + W'(4);
        disp    = {{SXW{off_i[OW-1]}}, off_i, 2'b00};
    end

    // Destinations and return address.
    always_comb begin
        br_tgt_o = slot_pc + disp;
        jp_tgt_o = {slot_pc[W-1 -: PGW], idx_i, 2'b00};
        link_o   = pc_i + W'(8);
    end
endmodule

// File: rtl/bju_top.sv
// Module: branch and jump target unit; registers one decision per cycle.
// Assumes the decoder supplies a valid strobe and the operand values are
// already forwarded. Misaligned register jumps are reported, not taken.
module bju_top
    import bju_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int OW = OFFW,
    parameter int IW = IDXW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vld_i,
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   pc_i,
    input  logic [W-1:0]   rs_i,
    input  logic [W-1:0]   rt_i,
    input  logic [OW-1:0]  off_i,
    input  logic [IW-1:0]  idx_i,
    output logic           taken_o,
    output logic [W-1:0]   target_o,
    output logic           link_we_o,
    output logic [W-1:0]   link_val_o,
    output logic           addr_err_o
);
    bju_dec_t     dec;
    logic [W-1:0] br_tgt;
    logic [W-1:0] jp_tgt;
    logic [W-1:0] link_val;
    logic         misalign;
    logic         nx_taken;
    logic         nx_link;
    logic         nx_err;
    logic [W-1:0] nx_tgt;

    bju_cond #(.W(W)) u_cond (
        .op_i (op_i),
        .rs_i (rs_i),
        .rt_i (rt_i),
        .dec_o(dec)
    );

    bju_addr #(.W(W), .OW(OW), .IW(IW)) u_addr (
        .pc_i    (pc_i),
        .off_i   (off_i),
        .idx_i   (idx_i),
        .br_tgt_o(br_tgt),
        .jp_tgt_o(jp_tgt),
        .link_o  (link_val)
    );

    // Combine decode, condition and alignment into next-state values.
    always_comb begin
        misalign = dec.is_jr & (rs_i[1:0] != 2'b00);
        nx_err   = vld_i & misalign;
        nx_taken = vld_i & dec.cond & ~misalign;
        nx_link  = vld_i & dec.is_link & ~misalign;
        if (dec.is_jr)      nx_tgt = rs_i;
        else if (dec.is_jp) nx_tgt = jp_tgt;
        else                nx_tgt = br_tgt;
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o    <= 1'b0;
            link_we_o  <= 1'b0;
            addr_err_o <= 1'b0;
            target_o   <= '0;
            link_val_o <= '0;
        end else begin
            taken_o    <= nx_taken;
            link_we_o  <= nx_link;
            addr_err_o <= nx_err;
            if (vld_i) begin
                target_o   <= nx_tgt;
                link_val_o <= link_val;
            end
        end
    end

    // An error cancels both the transfer and the link write.
    p_err_cancels_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_o |-> (!taken_o && !link_we_o));

    // A link write carries the instruction address plus 8.
    p_link_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_val_o == $past(pc_i) + W'(8)));

    // No valid input, no activity on the next cycle.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> (!taken_o && !link_we_o && !addr_err_o));

    // A taken register jump lands on a word boundary.
    p_reg_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (target_o[1:0] == 2'b00 || $past(op_i) != OP_JR && $past(op_i) != OP_JRL));

    // Reset clears every flag on the following edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!taken_o && !link_we_o && !addr_err_o));
endmodule

// File: tb/test_bju_top.sv
// Bench: behavioural reference model compared against the unit every cycle.
module test_bju_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] rs_i = '0;
    logic [31:0] rt_i = '0;
    logic [15:0] off_i = '0;
    logic [25:0] idx_i = '0;
    logic        taken_o;
    logic [31:0] target_o;
    logic        link_we_o;
    logic [31:0] link_val_o;
    logic        addr_err_o;

    int total = 0;
    int bad   = 0;

    bju_top i_bju_top (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .op_i(op_i), .pc_i(pc_i),
        .rs_i(rs_i), .rt_i(rt_i), .off_i(off_i), .idx_i(idx_i),
        .taken_o(taken_o), .target_o(target_o), .link_we_o(link_we_o),
        .link_val_o(link_val_o), .addr_err_o(addr_err_o)
    );

    always #5 clk = ~clk;

    // Expected outputs for the most recently applied stimulus.
    bit          e_taken, e_link, e_err;
    logic [31:0] e_tgt, e_lval;
    string       e_req;

    function automatic string req_name(input int op, input bit err);
        if (err) return "R4";
        case (op)
            1, 2: return "R2";
            3, 4: return "R3";
            5, 6: return "R5";
            7, 8, 9, 10: return "R6";
            11, 12: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference: written from the requirements with plain integer arithmetic.
    task automatic model(input bit v, input int op, input logic [31:0] pc,
                         input logic [31:0] rs, input logic [31:0] rt,
                         input logic [15:0] off, input logic [25:0] idx);
        longint s;
        bit cnd, jr, lnk;
        e_taken = 0; e_link = 0; e_err = 0; e_req = "R8";
        if (!v) return;
        s = longint'($signed(rs));
        cnd = 0; jr = (op == 3 || op == 4);
        lnk = (op == 2 || op == 4 || op == 11 || op == 12);
        case (op)
            1, 2, 3, 4: cnd = 1;
            5:  cnd = (rs == rt);
            6:  cnd = (rs != rt);
            7:  cnd = (s <= 0);
            8:  cnd = (s > 0);
            9, 11:  cnd = (s < 0);
            10, 12: cnd = (s >= 0);
            default: cnd = 0;
        endcase
        if (jr && rs[1:0] != 0) begin
            e_err = 1; cnd = 0; lnk = 0;
        end
        e_taken = cnd;
        e_link  = lnk;
        e_lval  = pc + 32'd8;
        if (op == 1 || op == 2)
            e_tgt = {((pc + 32'd4) >> 28) & 32'hF} << 28 | ({6'd0, idx} << 2);
        else if (jr)
            e_tgt = rs;
        else
            e_tgt = pc + 32'd4 + 32'(longint'($signed(off)) * 4);
        e_req = req_name(op, e_err);
    endtask

    task automatic compare();
        chk(e_req, "taken", {31'd0, taken_o}, {31'd0, e_taken});
        chk(e_req == "R9" ? "R9" : "R7", "link_we", {31'd0, link_we_o}, {31'd0, e_link});
        chk(e_req, "addr_err", {31'd0, addr_err_o}, {31'd0, e_err});
        if (e_taken) chk(e_req == "R9" ? "R9" : (off_i[15] ? "R10" : e_req), "target", target_o, e_tgt);
        if (e_link)  chk("R7", "link_val", link_val_o, e_lval);
    endtask

    // Apply one operation at the falling edge, check it after the next rise.
    task automatic step(input bit v, input int op, input logic [31:0] pc,
                        input logic [31:0] rs, input logic [31:0] rt,
                        input logic [15:0] off, input logic [25:0] idx);
        @(negedge clk);
        vld_i = v; op_i = op[3:0]; pc_i = pc; rs_i = rs; rt_i = rt;
        off_i = off; idx_i = idx;
        model(v, op, pc, rs, rt, off, idx);
        @(negedge clk);
        compare();
    endtask

    function automatic logic [31:0] pick(input logic [31:0] r);
        case (r[2:0])
            0: return 32'h0;
            1: return 32'h8000_0000;
            2: return 32'h7FFF_FFFF;
            3: return 32'hFFFF_FFFF;
            default: return $urandom();
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        // R1: flags cleared while reset is held, even with a valid jump present.
        vld_i = 1; op_i = 4'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "taken in reset", {31'd0, taken_o}, 0);
        chk("R1", "link_we in reset", {31'd0, link_we_o}, 0);
        chk("R1", "addr_err in reset", {31'd0, addr_err_o}, 0);
        vld_i = 0;
        rst_n = 1;

        // R2: paged jump, including the page carry from the last slot of a page.
        step(1, 1, 32'h1234_5670, 0, 0, 0, 26'h2AB_CDEF);
        step(1, 2, 32'h0FFF_FFFC, 0, 0, 0, 26'h000_0010);
        // R3 / R4: register jumps aligned and misaligned.
        step(1, 3, 32'h100, 32'hDEAD_BEE0, 0, 0, 0);
        step(1, 4, 32'h200, 32'h0000_4000, 0, 0, 0);
        step(1, 3, 32'h300, 32'h0000_4002, 0, 0, 0);
        step(1, 4, 32'h400, 32'h0000_4001, 0, 0, 0);
        // R5: two-register branches, both outcomes.
        step(1, 5, 32'h1000, 32'h55, 32'h55, 16'h0004, 0);
        step(1, 5, 32'h1000, 32'h55, 32'h56, 16'h0004, 0);
        step(1, 6, 32'h1000, 32'h55, 32'h56, 16'h0010, 0);
        // R6: zero compares on the signed edges.
        step(1, 7, 32'h2000, 32'h0, 0, 16'h1, 0);
        step(1, 8, 32'h2000, 32'h0, 0, 16'h1, 0);
        step(1, 8, 32'h2000, 32'h7FFF_FFFF, 0, 16'h1, 0);
        step(1, 9, 32'h2000, 32'h8000_0000, 0, 16'h1, 0);
        step(1, 10, 32'h2000, 32'h0, 0, 16'h1, 0);
        // R7: linking branches write register 31 taken or not.
        step(1, 11, 32'h3000, 32'h1, 0, 16'h2, 0);
        step(1, 12, 32'h3000, 32'hFFFF_FFF0, 0, 16'h2, 0);
        // R10: backwards displacement wrapping below zero.
        step(1, 10, 32'h0000_0008, 32'h0, 0, 16'hFFF0, 0);
        step(1, 5, 32'h0004_0000, 32'h7, 32'h7, 16'h8000, 0);
        // R9: unused codes do nothing; R8: invalid strobe does nothing.
        step(1, 0, 32'h500, 0, 0, 16'h1, 26'h1);
        step(1, 13, 32'h500, 0, 0, 16'h1, 26'h1);
        step(1, 15, 32'h500, 0, 0, 16'h1, 26'h1);
        step(0, 2, 32'h600, 0, 0, 16'h1, 26'h1);

        // Seeded mixed stream for all codes.
        void'($urandom(32'd7));
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            a = pick($urandom());
            b = ($urandom() % 4 == 0) ? a : pick($urandom());
            step(($urandom() % 8) != 0, int'($urandom() % 16), $urandom() & 32'hFFFF_FFFC,
                 a, b, 16'($urandom()), 26'($urandom()));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule